// File: doc/BRIEF.md
# Audio-Codec Link Frame Transmitter

This block is the controller-side sender of a time-division multiplexed serial link to an audio codec. It runs on the bit clock that the codec supplies. Each frame is 256 bit times long. It opens with a 16-bit tag word that describes the frame. Twelve 20-bit data slots follow the tag. The block drives the frame-start strobe and the serial data line. Both change on rising clock edges, so the codec can sample them on falling edges.

The user logic presents twelve slot words, one valid flag per slot and a two-bit codec identifier. Once per frame the block takes a snapshot of these inputs into its frame register and raises a one-cycle load pulse. The user may then prepare the next frame's words without disturbing the frame being sent. Nothing is sent until the enable input is raised. Clearing the enable lets the current frame finish, after which the link goes quiet.

Top module: `tdm_link_tx`

## Requirements
- R1: After reset, and while the block is idle with `en_i` low, `sdo_o`, `sync_o` and `load_o` are all 0.
- R2: From idle, the first rising edge that samples `en_i` high sets `load_o` and `sync_o` together, with `sdo_o` = 0. `load_o` is high for exactly one cycle. Frame bit F0 appears in the next cycle, and F1 to F255 follow one per cycle.
- R3: `sync_o` is high while F255 of the previous frame (or the idle 0) is on the line and while F0 to F14 are on the line. It is low from F15 through F254.
- R4: The tag is F0 to F15, with F0 sent first. F0 is the OR of all slot valid flags. F1 to F12 carry the valid flags of slots 1 to 12 in that order, with `slot_vld_i[11]` as slot 1 and `slot_vld_i[0]` as slot 12. F13 is 0. F14 is `codec_id_i[1]` and F15 is `codec_id_i[0]`.
- R5: Slot n (1 to 12) occupies F(16+20·(n-1)) to F(35+20·(n-1)) and is sent bit 19 first. Slot 1 is taken from `slot_data_i[239:220]` and slot 12 from `slot_data_i[19:0]`. Slot 1 bit 19, the read/write flag of a control access, is therefore at F16.
- R6: A slot whose valid flag is 0 is sent as twenty zero bits, whatever its data input holds.
- R7: Slot data, valid flags and codec ID are sampled on the rising edge that sets `load_o`. Changes made after that edge have no effect on the frame being sent.
- R8: While `en_i` stays high, frames follow back to back. The cycle in which F255 is on the line is also the cycle in which `sync_o` and `load_o` rise for the next frame, so load pulses are exactly 256 cycles apart.
- R9: `en_i` is sampled on the edge that puts F255 on the line. If it is low there, F255 is still sent, but without `sync_o` or `load_o`. The block then returns to idle, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock from the codec; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Start and keep framing; sampled at frame boundaries |
| slot_data_i | input | 240 | Twelve 20-bit slot words; slot 1 in the most significant 20 bits |
| slot_vld_i | input | 12 | Per-slot valid flags; bit 11 is slot 1 |
| codec_id_i | input | 2 | Codec identifier sent in the two last tag bits |
| sync_o | output | 1 | Frame-start strobe, high for 16 bit times |
| sdo_o | output | 1 | Serial frame data, most significant bit first |
| load_o | output | 1 | One-cycle pulse: inputs were captured on this edge |

## Verification
On every cycle, the embedded assertions check the strobe structure. A rising strobe always comes with a load pulse. A load pulse never lasts two cycles. The strobe always drops after the fifteenth tag bit. An idle block that is not enabled never starts a frame. The bit content is a different matter. Tag layout, slot order and bit order, zeroing of invalid slots, and isolation of the frame from inputs changed mid-frame can only be shown by the directed scenarios, which rebuild every frame bit by bit. The same holds for the orderly stop, in which F255 is still sent after the enable is dropped.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int DEF_SLOT_W    = 20;
    localparam int DEF_NUM_SLOTS = 12;
    localparam int DEF_TAG_W     = 16;
    localparam int DEF_ID_W      = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Commands from the sequencer to the shift register.
    // cap: drive the last remaining bit and load a fresh frame
    // adv: drive the next bit and shift
    typedef struct packed {
        logic cap;
        logic adv;
    } shift_ctl_t;

    function automatic int frame_len(input int tag_w, input int num_slots, input int slot_w);
        return tag_w + num_slots * slot_w;
    endfunction

endpackage

// File: rtl/tdm_tx_frame_build.sv
module tdm_tx_frame_build
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W    = DEF_SLOT_W,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int ID_W      = DEF_ID_W
) (
    input  logic [NUM_SLOTS*SLOT_W-1:0]                      slot_data_i,
    input  logic [NUM_SLOTS-1:0]                             slot_vld_i,
    input  logic [ID_W-1:0]                                  codec_id_i,
    output logic [frame_len(TAG_W, NUM_SLOTS, SLOT_W)-1:0]   frame_o
);

    localparam int DATA_W = NUM_SLOTS * SLOT_W;
    localparam int PAD_W  = TAG_W - 1 - NUM_SLOTS - ID_W;

    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] masked;

    // Tag word: frame-valid, per-slot flags (slot 1 first), pad, codec ID
    generate
        if (PAD_W > 0) begin : g_pad
            assign tag = {(|slot_vld_i), slot_vld_i, {PAD_W{1'b0}}, codec_id_i};
        end else begin : g_nopad
            assign tag = {(|slot_vld_i), slot_vld_i, codec_id_i};
        end
    endgenerate

    // Zero each slot whose flag is clear
    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign masked[s*SLOT_W +: SLOT_W] =
                slot_data_i[s*SLOT_W +: SLOT_W] & {SLOT_W{slot_vld_i[s]}};
        end
    endgenerate

    assign frame_o = {tag, masked};

endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift
    import tdm_tx_pkg::*;
#(
    parameter int FRAME_LEN = frame_len(DEF_TAG_W, DEF_NUM_SLOTS, DEF_SLOT_W)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  shift_ctl_t           ctl_i,
    input  logic [FRAME_LEN-1:0] frame_i,
    output logic                 sdo_o
);

    logic [FRAME_LEN-1:0] shreg_q;
    logic                 sdo_q;

    // The register shifts in zeros, so it holds all zeros once a frame has
    // drained; a capture from idle therefore drives a 0 on the line.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
            sdo_q   <= 1'b0;
        end else if (ctl_i.cap) begin
            sdo_q   <= shreg_q[FRAME_LEN-1];
            shreg_q <= frame_i;
        end else if (ctl_i.adv) begin
            sdo_q   <= shreg_q[FRAME_LEN-1];
            shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
        end else begin
            sdo_q   <= 1'b0;
        end
    end

    assign sdo_o = sdo_q;

    // R2: the sequencer never asks for a load and a shift at once
    ctl_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ctl_i.cap && ctl_i.adv));

endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
    import tdm_tx_pkg::*;
#(
    parameter int FRAME_LEN = frame_len(DEF_TAG_W, DEF_NUM_SLOTS, DEF_SLOT_W),
    parameter int TAG_W     = DEF_TAG_W
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    output shift_ctl_t ctl_o,
    output logic       sync_o,
    output logic       load_o
);

    localparam int POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] PRE_POS    = POS_W'(FRAME_LEN - 2);
    localparam logic [POS_W-1:0] SYNC_END   = POS_W'(TAG_W - 1);
    localparam logic [POS_W-1:0] SYNC_FINAL = POS_W'(TAG_W - 2);

    seq_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;     // index of the bit on the line
    logic             stop_q, stop_d;
    logic             sync_q, sync_d;
    logic             load_q;
    shift_ctl_t       ctl;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        pos_d   = pos_q;
        stop_d  = stop_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    ctl.cap = 1'b1;
                    state_d = ST_RUN;
                    pos_d   = LAST_POS;
                end
            end
            ST_RUN: begin
                if (pos_q == PRE_POS) begin
                    // Frame boundary: F255 goes out now
                    pos_d = LAST_POS;
                    if (en_i) begin
                        ctl.cap = 1'b1;
                    end else begin
                        ctl.adv = 1'b1;
                        stop_d  = 1'b1;
                    end
                end else if (pos_q == LAST_POS) begin
                    pos_d = '0;
                    if (stop_q) begin
                        state_d = ST_IDLE;
                        stop_d  = 1'b0;
                    end else begin
                        ctl.adv = 1'b1;
                    end
                end else begin
                    ctl.adv = 1'b1;
                    pos_d   = pos_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        sync_d = ctl.cap | (ctl.adv && (pos_d != LAST_POS) && (pos_d < SYNC_END));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            stop_q  <= 1'b0;
            sync_q  <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            stop_q  <= stop_d;
            sync_q  <= sync_d;
            load_q  <= ctl.cap;
        end
    end

    assign ctl_o  = ctl;
    assign sync_o = sync_q;
    assign load_o = load_q;

    // R2
    sync_has_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sync_o) |-> load_o);

    // R2
    load_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |=> !load_o);

    // R3
    sync_tag_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sync_o && !load_o && pos_q == SYNC_FINAL) |=> !sync_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && !en_i) |=> (!sync_o && !load_o));

    // R9
    stop_no_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_q |-> (!load_o && !sync_o));

endmodule

// File: rtl/tdm_link_tx.sv
module tdm_link_tx
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W    = DEF_SLOT_W,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int ID_W      = DEF_ID_W
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        en_i,
    input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data_i,
    input  logic [NUM_SLOTS-1:0]        slot_vld_i,
    input  logic [ID_W-1:0]             codec_id_i,
    output logic                        sync_o,
    output logic                        sdo_o,
    output logic                        load_o
);

    localparam int FRAME_LEN = frame_len(TAG_W, NUM_SLOTS, SLOT_W);

    logic [FRAME_LEN-1:0] frame;
    shift_ctl_t           ctl;

    tdm_tx_frame_build #(
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .TAG_W     (TAG_W),
        .ID_W      (ID_W)
    ) i_build (
        .slot_data_i (slot_data_i),
        .slot_vld_i  (slot_vld_i),
        .codec_id_i  (codec_id_i),
        .frame_o     (frame)
    );

    tdm_tx_seq #(
        .FRAME_LEN (FRAME_LEN),
        .TAG_W     (TAG_W)
    ) i_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .ctl_o  (ctl),
        .sync_o (sync_o),
        .load_o (load_o)
    );

    tdm_tx_shift #(
        .FRAME_LEN (FRAME_LEN)
    ) i_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ctl_i   (ctl),
        .frame_i (frame),
        .sdo_o   (sdo_o)
    );

endmodule

// File: tb/test_tdm_link_tx.sv
module test_tdm_link_tx;

    logic         clk = 1'b0;
    logic         rst_i;
    logic         en_i;
    logic [239:0] data_i;
    logic [11:0]  vld_i;
    logic [1:0]   id_i;
    logic         sync_o, sdo_o, load_o;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tdm_link_tx i_tdm_link_tx (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .en_i        (en_i),
        .slot_data_i (data_i),
        .slot_vld_i  (vld_i),
        .codec_id_i  (id_i),
        .sync_o      (sync_o),
        .sdo_o       (sdo_o),
        .load_o      (load_o)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected frame built from the requirement text (R4, R5, R6)
    function automatic logic [255:0] mk_frame(input logic [239:0] d, input logic [11:0] v,
                                              input logic [1:0] id);
        logic [255:0] f;
        f[255]     = |v;
        f[254:243] = v;
        f[242]     = 1'b0;
        f[241:240] = id;
        for (int s = 0; s < 12; s++) begin
            f[239-20*s -: 20] = v[11-s] ? d[239-20*s -: 20] : 20'h0;
        end
        return f;
    endfunction

    function automatic logic [239:0] mk_data(input logic [7:0] seed);
        logic [239:0] d;
        for (int s = 0; s < 12; s++) begin
            d[239-20*s -: 20] = {4'(s + 1) ^ seed[3:0], seed, 8'(s * 37 + 5)};
        end
        return d;
    endfunction

    task automatic t_reset();
        rst_i = 1'b1; en_i = 1'b0; data_i = '0; vld_i = '0; id_i = '0;
        repeat (4) @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
        check({sdo_o, sync_o, load_o} == 3'b000, "R1", "reset outputs",
              256'({sdo_o, sync_o, load_o}), 256'(0));
        begin
            int busy = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sdo_o || sync_o || load_o) busy++;
            end
            check(busy == 0, "R1", "idle cycles with activity", 256'(busy), 256'(0));
        end
    endtask

    task automatic t_start(input logic [239:0] d, input logic [11:0] v, input logic [1:0] id);
        int waited;
        data_i = d; vld_i = v; id_i = id; en_i = 1'b1;
        waited = 0;
        @(negedge clk);
        while (!load_o && waited < 600) begin
            @(negedge clk);
            waited++;
        end
        check(load_o == 1'b1, "R2", "load pulse after enable", 256'(load_o), 256'(1));
        check({sync_o, sdo_o} == 2'b10, "R2", "sync/sdo on start cycle",
              256'({sync_o, sdo_o}), 256'(2'b10));
    endtask

    // Called on the sample where load_o is seen; applies the next inputs at once
    task automatic run_frame(input logic [255:0] expf, input logic [239:0] nd,
                             input logic [11:0] nv, input logic [1:0] nid,
                             input logic nen, input logic nxt, input string req);
        logic [255:0] got;
        int sync_bad, load_bad;
        data_i = nd; vld_i = nv; id_i = nid; en_i = nen;
        got = '0; sync_bad = 0; load_bad = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            got[255-k] = sdo_o;
            if (k < 255) begin
                if (sync_o !== 1'(k < 15)) sync_bad++;
                if (load_o !== 1'b0) load_bad++;
            end
        end
        check(got[255:240] == expf[255:240], "R4", "tag bits",
              256'(got[255:240]), 256'(expf[255:240]));
        check(got[239:0] == expf[239:0], req, "slot bits",
              256'(got[239:0]), 256'(expf[239:0]));
        check(sync_bad == 0, "R3", "sync pattern errors", 256'(sync_bad), 256'(0));
        check(load_bad == 0, "R2", "extra load cycles", 256'(load_bad), 256'(0));
        if (nxt)
            check({load_o, sync_o} == 2'b11, "R8", "next frame starts on F255",
                  256'({load_o, sync_o}), 256'(2'b11));
        else
            check({load_o, sync_o} == 2'b00, "R9", "no new frame after disable",
                  256'({load_o, sync_o}), 256'(2'b00));
    endtask

    task automatic t_quiet(input int cycles);
        int busy = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sdo_o || sync_o || load_o) busy++;
        end
        check(busy == 0, "R9", "activity after stop", 256'(busy), 256'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [239:0] da, db, dc, dd, de;
        logic [11:0]  va, vb, vc, vd, ve;
        logic [1:0]   ia, ib, ic, id, ie;
        da = mk_data(8'h9C); va = 12'hFFF; ia = 2'b10;
        db = mk_data(8'h3A); vb = 12'hA53; ib = 2'b01;
        dc = mk_data(8'hF1); vc = 12'h000; ic = 2'b11;
        dd = mk_data(8'h66); vd = 12'hFFF; id = 2'b00; dd[0] = 1'b1;
        de = mk_data(8'hB8); ve = 12'h801; ie = 2'b10;

        t_reset();
        // R7: frame A is checked while B's inputs are already applied
        t_start(da, va, ia);
        run_frame(mk_frame(da, va, ia), db, vb, ib, 1'b1, 1'b1, "R7");
        // R6: partial valid mask
        run_frame(mk_frame(db, vb, ib), dc, vc, ic, 1'b1, 1'b1, "R6");
        // R4: no slot valid, frame-valid bit low
        run_frame(mk_frame(dc, vc, ic), dd, vd, id, 1'b1, 1'b1, "R4");
        // R9: enable dropped during the frame, F255 still sent
        run_frame(mk_frame(dd, vd, id), dd, vd, id, 1'b0, 1'b0, "R9");
        t_quiet(300);
        // R5: restart from idle, slot 1 and slot 12 placement, bit 19 first
        t_start(de, ve, ie);
        run_frame(mk_frame(de, ve, ie), de, ve, ie, 1'b0, 1'b0, "R5");
        t_quiet(20);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule